// File: doc/BRIEF.md
# Comma-Aligned 10-Bit Word Deserializer

This block turns a retimed serial stream, one bit per cycle of a single bit-rate clock, into 10-bit parallel words. Bits fill each word from bit 0 upward, so the earliest bit of a word sits in bit 0. A divide-by-ten bit counter marks the word boundary. When alignment is enabled, a 7-bit sliding window watches for the positive-disparity comma. On a match the boundary is moved so that the comma opens the next output word, and a sync flag marks that word.

Two byte clocks run at one twentieth of the bit rate, in opposite phase. They toggle at word boundaries and restart from the new boundary after a realignment. A small two-state machine stretches the current byte-clock level whenever the realignment would otherwise leave it short. The state RUN is normal operation, where every boundary toggles both clocks. The state STRETCH means the next boundary is passed without a toggle. The transitions are:
- RUN to STRETCH, on a realignment that leaves fewer than 7 bits since the last toggle.
- STRETCH to RUN, at the suppressed boundary or on a later realignment that is not short.
- RUN to RUN and STRETCH to STRETCH otherwise.

A serial-source select takes the local transmit stream instead of the line input for internal loopback. A signal-loss input forces the serial bit high.

Top module: `comma_word_deser`

## Requirements
- R1: After synchronous reset `word_out` is 0, `sync_out` is 0, `bclk_a` is 0 and `bclk_b` is 1.
- R2: Serial bit k of a word (k = 0 first received) appears in `word_out[k]`. `word_out` and `sync_out` change only in the cycle after the tenth bit of a word is sampled, and hold for the rest of the word.
- R3: Without realignment the boundary repeats every 10 bit cycles, and the first word after reset is made of the first 10 bits sampled after reset is released.
- R4: With `align_en` high, the comma (reception order 0,0,1,1,1,1,1) is detected over the last 7 bits received. If it does not already start a word, the boundary moves so that the comma occupies bits 0 to 6 of the next word.
- R5: `sync_out` is high for exactly the output word that holds a detected comma, and low for other words.
- R6: With `align_en` low, a comma neither moves the boundary nor raises `sync_out`.
- R7: `bclk_b` is always the inverse of `bclk_a`. Both toggle at each word boundary, giving a period of 20 bit cycles in steady state.
- R8: After a realignment the byte clocks next toggle at the new boundary. If that would end a level shorter than 10 bit cycles, that toggle is skipped and the level is stretched. No level is ever shorter than 10 bit cycles.
- R9: A comma that already starts a word raises `sync_out` but leaves the boundary and byte clocks untouched, so levels stay exactly 10 bit cycles.
- R10: While `sig_lost` is high the serial bit is taken as 1, so a word sampled wholly under signal loss reads 10'h3FF.
- R11: With `loop_en` high the deserializer takes `tx_bit` as its serial input. With it low it takes `line_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| line_bit | input | 1 | Retimed line serial bit |
| tx_bit | input | 1 | Local transmit serial bit for loopback |
| loop_en | input | 1 | Select `tx_bit` as serial source |
| sig_lost | input | 1 | Signal loss, forces the serial bit high |
| align_en | input | 1 | Enable comma search and realignment |
| word_out | output | 10 | Parallel word, bit 0 received first |
| sync_out | output | 1 | High for the word that carries a comma |
| bclk_a | output | 1 | Byte clock, half word rate |
| bclk_b | output | 1 | Byte clock, opposite phase of `bclk_a` |

## Verification
The bench places commas at offsets that force a realignment. A design that miscounted the snap position would then emit the comma shifted out of bits 0 to 6, or flag the wrong word. A run of commas that already sit on the boundary must leave every byte-clock level at exactly 10 cycles; a design that reloaded the counter regardless would still look right, but one that restarted the clocks would shorten a level. Realignments right after a toggle exercise the stretch path, where a missing stretch shows as a level shorter than 10 cycles. A misaligned comma with alignment off, signal loss over stale zeros, and loopback with an inverted line input check that each of these controls acts on the right bit.

// File: rtl/cdes_pkg.sv
package cdes_pkg;
    // Byte-clock phase control: RUN toggles at every boundary,
    // STRETCH lets one boundary pass without a toggle.
    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_STRETCH = 1'b1
    } phase_st_e;
endpackage

// File: rtl/cdes_bit_src.sv
module cdes_bit_src (
    input  logic line_bit,
    input  logic loop_bit,
    input  logic loop_en,
    input  logic sig_lost,
    output logic bit_sel
);
    // Signal loss wins over both sources, then the loopback select.
    always_comb begin
        if (sig_lost)
            bit_sel = 1'b1;
        else if (loop_en)
            bit_sel = loop_bit;
        else
            bit_sel = line_bit;
    end
endmodule

// File: rtl/cdes_window.sv
module cdes_window #(
    parameter int                 WORD_W    = 10,
    parameter int                 COMMA_W   = 7,
    parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_nx,
    output logic              comma_seen
);
    logic [WORD_W-1:0] sh_q;

    // Newest bit enters at the top; after a full word the first bit is at 0.
    assign word_nx    = {bit_in, sh_q[WORD_W-1:1]};
    // The last COMMA_W bits, oldest at the low end, against the pattern.
    assign comma_seen = (word_nx[WORD_W-1 -: COMMA_W] == COMMA_PAT);

    // Reset to ones so the stale fill can never supply the leading zeros.
    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '1;
        else
            sh_q <= word_nx;
    end
endmodule

// File: rtl/cdes_frame_fsm.sv
module cdes_frame_fsm
    import cdes_pkg::*;
#(
    parameter int WORD_W  = 10,
    parameter int COMMA_W = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic seek_hit,
    output logic word_done,
    output logic bclk_a,
    output logic bclk_b
);
    localparam int CNT_W   = $clog2(WORD_W);
    localparam int AGE_MAX = 2 * WORD_W;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] SNAP_CNT  = CNT_W'(COMMA_W);
    localparam logic [AGE_W-1:0] AGE_TOP   = AGE_W'(AGE_MAX);
    localparam logic [AGE_W-1:0] SHORT_LIM = AGE_W'(COMMA_W);
    localparam logic [AGE_W-1:0] MIN_HOLD  = AGE_W'(WORD_W - 1);

    phase_st_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_adv;
    logic [AGE_W-1:0] age_q, age_d, age_adv;
    logic             toggle, realign;

    always_comb begin
        word_done = (cnt_q == LAST_CNT);
        cnt_adv   = word_done ? '0 : cnt_q + 1'b1;
        toggle    = word_done && (st_q == ST_RUN);
        age_adv   = toggle ? '0 : ((age_q == AGE_TOP) ? age_q : age_q + 1'b1);
        // A comma whose natural position already matches leaves all alone.
        realign   = seek_hit && (cnt_adv != SNAP_CNT);

        unique case (st_q)
            ST_RUN:     st_d = ST_RUN;
            ST_STRETCH: st_d = word_done ? ST_RUN : ST_STRETCH;
        endcase
        if (realign)
            st_d = (age_adv < SHORT_LIM) ? ST_STRETCH : ST_RUN;

        cnt_d = realign ? SNAP_CNT : cnt_adv;
        age_d = age_adv;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
            age_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            age_q <= age_d;
        end
    end

    // Outputs: two independent flops, each toggled at an unsuppressed boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_a <= 1'b0;
            bclk_b <= 1'b1;
        end else if (toggle) begin
            bclk_a <= ~bclk_a;
            bclk_b <= ~bclk_b;
        end
    end

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_CNT);

    assert_bclk_opposite_R7: assert property (@(posedge clk) disable iff (rst)
        bclk_a != bclk_b);

    assert_level_min_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(bclk_a) |-> $past(age_q) >= MIN_HOLD);
endmodule

// File: rtl/comma_word_deser.sv
module comma_word_deser #(
    parameter int                 WORD_W    = 10,
    parameter int                 COMMA_W   = 7,
    parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_bit,
    input  logic              tx_bit,
    input  logic              loop_en,
    input  logic              sig_lost,
    input  logic              align_en,
    output logic [WORD_W-1:0] word_out,
    output logic              sync_out,
    output logic              bclk_a,
    output logic              bclk_b
);
    localparam int LOSS_W = $clog2(WORD_W + 1);
    localparam logic [LOSS_W-1:0] LOSS_TOP  = LOSS_W'(WORD_W);
    localparam logic [LOSS_W-1:0] LOSS_NEED = LOSS_W'(WORD_W - 1);

    logic              bit_sel;
    logic [WORD_W-1:0] word_nx;
    logic              comma_seen, seek_hit, word_done;
    logic              pend_q;
    logic [LOSS_W-1:0] los_run_q;

    cdes_bit_src u_src (
        .line_bit (line_bit),
        .loop_bit (tx_bit),
        .loop_en  (loop_en),
        .sig_lost (sig_lost),
        .bit_sel  (bit_sel)
    );

    cdes_window #(
        .WORD_W    (WORD_W),
        .COMMA_W   (COMMA_W),
        .COMMA_PAT (COMMA_PAT)
    ) u_win (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (bit_sel),
        .word_nx    (word_nx),
        .comma_seen (comma_seen)
    );

    assign seek_hit = comma_seen && align_en;

    cdes_frame_fsm #(
        .WORD_W  (WORD_W),
        .COMMA_W (COMMA_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .seek_hit  (seek_hit),
        .word_done (word_done),
        .bclk_a    (bclk_a),
        .bclk_b    (bclk_b)
    );

    // Parallel word, sync flag and the pending-comma mark.
    // A hit in the same cycle as a boundary belongs to the next word.
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out <= '0;
            sync_out <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (word_done) begin
                word_out <= word_nx;
                sync_out <= pend_q;
            end
            if (seek_hit)
                pend_q <= 1'b1;
            else if (word_done)
                pend_q <= 1'b0;
        end
    end

    // Checker-only run length of signal loss, saturating at one word.
    always_ff @(posedge clk) begin
        if (rst)
            los_run_q <= '0;
        else if (!sig_lost)
            los_run_q <= '0;
        else if (los_run_q != LOSS_TOP)
            los_run_q <= los_run_q + 1'b1;
    end

    assert_word_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !word_done |=> $stable(word_out) && $stable(sync_out));

    assert_loss_high_R10: assert property (@(posedge clk) disable iff (rst)
        (word_done && sig_lost && los_run_q >= LOSS_NEED) |=> word_out == '1);
endmodule

// File: tb/sim_comma_word_deser.sv
`timescale 1ns/1ps
module sim_comma_word_deser;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_bit = 1'b1, tx_bit = 1'b1, loop_en = 1'b0;
    logic       sig_lost = 1'b0, align_en = 1'b0;
    logic [9:0] word_out;
    logic       sync_out, bclk_a, bclk_b;

    always #5 clk = ~clk;

    comma_word_deser u0 (
        .clk(clk), .rst(rst), .line_bit(line_bit), .tx_bit(tx_bit),
        .loop_en(loop_en), .sig_lost(sig_lost), .align_en(align_en),
        .word_out(word_out), .sync_out(sync_out), .bclk_a(bclk_a), .bclk_b(bclk_b)
    );

    int checks = 0, errors = 0;
    string phase_tag = "R3";

    // Expected-value model, built from the requirements
    logic [9:0] m_sh = '1, m_word = '0;
    int  m_cnt = 0, m_age = 0;
    bit  m_str = 0, m_a = 0, m_pend = 0, m_sync = 0;
    // Byte-clock level tracking
    bit  prev_a = 0;
    int  lvl = 0;
    bit  exact_mode = 0;
    int  exact_skip = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_bit(input logic b, input logic al);
        logic [9:0] nsh;
        bit done, tog, hit;
        int ncnt, nage;
        nsh  = {b, m_sh[9:1]};
        done = (m_cnt == 9);
        ncnt = done ? 0 : m_cnt + 1;
        tog  = done && !m_str;
        nage = tog ? 0 : ((m_age >= 20) ? 20 : m_age + 1);
        if (done) begin
            m_word = nsh;
            m_sync = m_pend;
            m_pend = 0;
            if (tog) m_a = !m_a;
            m_str = 0;
        end
        hit = al && (nsh[9:3] == 7'b1111100);
        if (hit) begin
            m_pend = 1;
            if (ncnt != 7) begin
                ncnt  = 7;
                m_str = (nage < 7);
            end
        end
        m_sh  = nsh;
        m_cnt = ncnt;
        m_age = nage;
    endtask

    task automatic compare();
        int len;
        check(word_out === m_word, phase_tag, "word_out", word_out, m_word);
        check(sync_out === m_sync, phase_tag, "sync_out", {9'd0, sync_out}, {9'd0, m_sync});
        check(bclk_a === m_a, "R7", "bclk_a", {9'd0, bclk_a}, {9'd0, m_a});
        check(bclk_b === !m_a, "R7", "bclk_b", {9'd0, bclk_b}, {9'd0, !m_a});
        if (bclk_a !== prev_a) begin
            len = lvl + 1;
            check(len >= 10, "R8", "level length", 10'(len), 10'd10);
            if (exact_mode) begin
                if (exact_skip > 0) exact_skip--;
                else check(len == 10, "R9", "level length", 10'(len), 10'd10);
            end
            lvl = 0;
            prev_a = bclk_a;
        end else begin
            lvl++;
        end
    endtask

    // Drive one bit at a falling edge, let one rising edge pass, compare
    task automatic step(input logic lb, input logic tb, input logic lp,
                        input logic ls, input logic al);
        line_bit = lb; tx_bit = tb; loop_en = lp; sig_lost = ls; align_en = al;
        model_bit(ls ? 1'b1 : (lp ? tb : lb), al);
        @(negedge clk);
        compare();
    endtask

    task automatic send_word(input logic [9:0] w, input logic al);
        for (int i = 0; i < 10; i++) step(w[i], 1'b1, 1'b0, 1'b0, al);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [9:0] w;
        void'($urandom(32'h1D5E_7A11));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(word_out === 10'd0, "R1", "word_out", word_out, 10'd0);
        check(sync_out === 1'b0, "R1", "sync_out", {9'd0, sync_out}, 10'd0);
        check(bclk_a === 1'b0 && bclk_b === 1'b1, "R1", "bclk_a/b",
              {8'd0, bclk_a, bclk_b}, 10'b01);
        rst = 1'b0;

        // R3 / R2: first word from the first ten bits, bit 0 first
        phase_tag = "R3";
        w = 10'b1101001101;
        for (int i = 0; i < 9; i++) step(w[i], 1'b1, 1'b0, 1'b0, 1'b0);
        check(word_out === 10'd0, "R2", "word before tenth bit", word_out, 10'd0);
        step(w[9], 1'b1, 1'b0, 1'b0, 1'b0);
        check(word_out === w, "R3", "first word", word_out, w);

        // R4 / R5: misaligned comma pulls the boundary onto it
        phase_tag = "R4";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        w = 10'b0101111100;
        for (int i = 0; i < 10; i++) step(w[i], 1'b1, 1'b0, 1'b0, 1'b1);
        check(word_out === w, "R4", "comma word", word_out, w);
        check(sync_out === 1'b1, "R5", "sync on comma word", {9'd0, sync_out}, 10'd1);

        // R9: commas already on the boundary
        phase_tag = "R9";
        exact_mode = 1; exact_skip = 2;
        w = 10'b0101111100;
        for (int k = 0; k < 8; k++) begin
            send_word(w, 1'b1);
            check(sync_out === 1'b1, "R9", "sync on aligned comma", {9'd0, sync_out}, 10'd1);
        end
        exact_mode = 0;
        send_word(10'h3FF, 1'b1);
        check(sync_out === 1'b0, "R5", "sync after comma word", {9'd0, sync_out}, 10'd0);
        check(word_out === 10'h3FF, "R5", "word after comma", word_out, 10'h3FF);

        // R11: loopback and line selection
        phase_tag = "R11";
        w = 10'b1010010110;
        for (int i = 0; i < 10; i++) step(~w[i], w[i], 1'b1, 1'b0, 1'b0);
        check(word_out === w, "R11", "loopback word", word_out, w);
        w = 10'b0110101001;
        for (int i = 0; i < 10; i++) step(w[i], ~w[i], 1'b0, 1'b0, 1'b0);
        check(word_out === w, "R11", "line word", word_out, w);

        // R6: misaligned comma with alignment off
        phase_tag = "R6";
        w = 10'b1111110011;
        send_word(w, 1'b0);
        check(word_out === w, "R6", "word unaligned", word_out, w);
        check(sync_out === 1'b0, "R6", "no sync", {9'd0, sync_out}, 10'd0);
        send_word(10'h3FF, 1'b0);
        check(word_out === 10'h3FF, "R6", "boundary kept", word_out, 10'h3FF);

        // R10: signal loss over zero line data
        phase_tag = "R10";
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check(word_out === 10'h3FF, "R10", "word under loss", word_out, 10'h3FF);

        // Random traffic with inserted commas, compared every cycle
        phase_tag = "R4";
        for (int c = 0; c < 400; c++) begin
            logic al, lp, ls;
            al = ($urandom % 4) != 0;
            lp = ($urandom % 5) == 0;
            ls = ($urandom % 16) == 0;
            if ($urandom % 3 == 0) begin
                logic [6:0] cm;
                cm = 7'b1111100;
                for (int i = 0; i < 7; i++) begin
                    logic r;
                    r = 1'($urandom);
                    if (lp) step(r, cm[i], lp, ls, al);
                    else    step(cm[i], r, lp, ls, al);
                end
            end else begin
                int n;
                n = 1 + int'($urandom % 12);
                for (int i = 0; i < n; i++)
                    step(1'($urandom), 1'($urandom), lp, ls, al);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule